// File: doc/BRIEF.md
# Configuration Bitstream Streaming Controller

This block feeds a configuration bitstream to one or more downstream FPGAs. Software, or a DMA engine, writes the image as 32-bit words into a data window. The words land in an internal FIFO. A serializer splits each word into bytes, most significant byte first, and presents them on a byte-wide valid/ready output. A small register file holds the control word, a status word with sticky error flags, the FIFO capacity and occupancy in bytes, the programmed total length and the running count of bytes handed to the targets.

A load runs as follows. Software programs the total byte count and then sets the enable bit. In the paced mode it also sets the DMA bit, and the block then requests a burst of half the FIFO whenever at least half the FIFO is free. Once the programmed number of bytes has left the output, the block samples the targets' done input. It reports either success or a missing-done error and raises the interrupt. An error input from the targets ends the load early. Writing zero to the control word stops everything and clears the interrupt. Holding the enable and reset bits together drives the target reset line, and the next write of zero ends that pulse.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: After reset the control word, status word, interrupt, reset line, DMA request and output valid are all zero, and the control word (register index 0) reads back the last value written.
- R2: The target reset output is high exactly while the control word has both bit 0 (enable) and bit 1 (reset) set, and no byte is presented while it is high.
- R3: A write to the data window (address bit 3 set) is dropped while the block is disabled, while it is holding reset, or while the FIFO is full. A dropped write sets status bit 2 (overflow) and the interrupt.
- R4: Bytes leave most significant byte first. Output data and valid hold steady while ready is low, and a byte advances only on a cycle with valid and ready both high.
- R5: Register index 2 reads the FIFO capacity in bytes, index 3 reads the bytes held in the FIFO (four per stored word), and index 5 reads the count of bytes handed over since enable was last raised.
- R6: When the handed-over count reaches the total (register index 4) and the done input is high, status bit 0 sets, the interrupt rises and output valid stays low.
- R7: If the done input is low when the count reaches the total, status bit 3 sets instead of bit 0, and the interrupt rises.
- R8: A high error input during a load sets status bit 1, stops the output and raises the interrupt. It takes priority over completion evaluated in the same cycle.
- R9: Writing zero to the control word clears the interrupt, empties the FIFO and drops output valid and the DMA request. The clear takes priority over any interrupt event in the same cycle.
- R10: The DMA request is high only in a running load with control bit 2 set and at least half the FIFO free. It is never high without bit 2.
- R11: Status bit 18 mirrors the targets' done input.
- R12: A rising edge of the enable bit clears status bits 0 to 3 and the handed-over count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register or data-window write strobe |
| reg_addr_i | input | ADDR_W | Word address; bit 3 selects the data window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| cfg_data_o | output | 8 | Configuration byte to the targets |
| cfg_valid_o | output | 1 | Configuration byte valid |
| cfg_ready_i | input | 1 | Targets accept the byte |
| tgt_done_i | input | 1 | Targets report configuration done |
| tgt_err_i | input | 1 | Targets report a configuration error |
| cfg_rst_o | output | 1 | Reset request to the targets |
| irq_o | output | 1 | Completion or error interrupt |
| dma_req_o | output | 1 | Request for a half-FIFO burst |

## Verification
Completion evaluation and the target error input can land in the same cycle. The bench provokes this by handing over the last byte of a load and raising the error input for exactly the following cycle, which is the cycle in which the block compares the count against the total. The outcome is judged from the status word: the error flag must be set, and both the success flag and the missing-done flag must stay clear. A second collision, between the zero write to the control word and a pending interrupt event, is covered by a property on the interrupt line.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned WIN_BIT  = 3;
  // control bits
  localparam int unsigned CTRL_EN  = 0;
  localparam int unsigned CTRL_RST = 1;
  localparam int unsigned CTRL_DMA = 2;
  // status bits
  localparam int unsigned ST_OK     = 0;
  localparam int unsigned ST_TERR   = 1;
  localparam int unsigned ST_OVF    = 2;
  localparam int unsigned ST_NODONE = 3;
  localparam int unsigned ST_DONE   = 18;
  typedef enum logic [2:0] {
    RI_CTRL  = 3'd0,
    RI_STAT  = 3'd1,
    RI_CAP   = 3'd2,
    RI_USED  = 3'd3,
    RI_TOTAL = 3'd4,
    RI_CONS  = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/cfg_fifo.sv
module cfg_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= ptr_nxt(wp_q);
      if (pop_i)  rp_q <= ptr_nxt(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
endmodule

// File: rtl/cfg_byte_ser.sv
module cfg_byte_ser #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB    = WORD_W / BYTE_W,
  localparam int unsigned IW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              run_i,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pop_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              fire_o
);
  logic              have_q;
  logic [WORD_W-1:0] sh_q;
  logic [IW-1:0]     idx_q;
  logic              last, load;

  assign valid_o = have_q && run_i;
  assign fire_o  = valid_o && ready_i;
  assign last    = fire_o && (idx_q == IW'(NB - 1));
  // refill in the same cycle the final byte leaves: no bubble between words
  assign load    = run_i && avail_i && (!have_q || last);
  assign pop_o   = load;
  assign data_o  = sh_q[WORD_W-1 -: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
    end else if (flush_i) begin
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      have_q <= 1'b1;
      sh_q   <= word_i;
      idx_q  <= '0;
    end else if (last) begin
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (fire_o) begin
      sh_q  <= sh_q << BYTE_W;
      idx_q <= idx_q + IW'(1);
    end
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rstb_i,
  input  logic             dma_i,
  input  logic             en_rise_i,
  input  logic             zero_wr_i,
  input  logic             fire_i,
  input  logic             drop_i,
  input  logic             tgt_done_i,
  input  logic             tgt_err_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CW-1:0]    fifo_cnt_i,
  output logic             run_o,
  output logic             flush_o,
  output logic [CNT_W-1:0] consumed_o,
  output logic             ok_o,
  output logic             terr_o,
  output logic             ovf_o,
  output logic             nodone_o,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic             cfg_rst_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

  logic [CNT_W-1:0] cons_q;
  logic ok_q, terr_q, ovf_q, nodone_q, irq_q;
  logic stopped, active, hit, err_evt, evt;

  assign stopped = ok_q || terr_q || ovf_q || nodone_q;
  assign active  = en_i && !rstb_i && !stopped;
  assign hit     = active && (cons_q == total_i);
  assign run_o   = active && (cons_q != total_i);
  assign err_evt = active && tgt_err_i;
  assign evt     = err_evt || hit || drop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_q   <= '0;
      ok_q     <= 1'b0;
      terr_q   <= 1'b0;
      ovf_q    <= 1'b0;
      nodone_q <= 1'b0;
    end else if (en_rise_i) begin
      cons_q   <= '0;
      ok_q     <= 1'b0;
      terr_q   <= 1'b0;
      ovf_q    <= 1'b0;
      nodone_q <= 1'b0;
    end else begin
      if (fire_i) cons_q <= cons_q + CNT_W'(1);
      if (err_evt)         terr_q   <= 1'b1;
      else if (hit) begin
        if (tgt_done_i)    ok_q     <= 1'b1;
        else               nodone_q <= 1'b1;
      end
      if (drop_i) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (zero_wr_i) irq_q <= 1'b0;
    else if (evt)       irq_q <= 1'b1;
  end

  assign flush_o    = !en_i || rstb_i;
  assign consumed_o = cons_q;
  assign ok_o       = ok_q;
  assign terr_o     = terr_q;
  assign ovf_o      = ovf_q;
  assign nodone_o   = nodone_q;
  assign irq_o      = irq_q;
  assign dma_req_o  = run_o && dma_i && ((DEPTH_C - fifo_cnt_i) >= HALF_C);
  assign cfg_rst_o  = en_i && rstb_i;
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 4,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [7:0]        cfg_data_o,
  output logic              cfg_valid_o,
  input  logic              cfg_ready_i,
  input  logic              tgt_done_i,
  input  logic              tgt_err_i,
  output logic              cfg_rst_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  localparam logic [REG_W-1:0] CAP_BYTES = REG_W'(FIFO_DEPTH * 4);

  logic [REG_W-1:0] ctrl_q;
  logic [CNT_W-1:0] total_q, consumed;
  logic             win, ctrl_wr, total_wr, data_wr;
  logic             en_rise, zero_wr, accept, push, drop;
  logic             fifo_pop, fifo_empty, fifo_full, flush, run, fire;
  logic [31:0]      fifo_rdata;
  logic [CW-1:0]    fifo_cnt;
  logic             ok, terr, ovf, nodone;
  logic [REG_W-1:0] status;

  assign win      = reg_addr_i[WIN_BIT];
  assign ctrl_wr  = reg_wr_i && !win && (reg_addr_i[2:0] == RI_CTRL);
  assign total_wr = reg_wr_i && !win && (reg_addr_i[2:0] == RI_TOTAL);
  assign data_wr  = reg_wr_i && win;
  assign en_rise  = ctrl_wr && reg_wdata_i[CTRL_EN] && !ctrl_q[CTRL_EN];
  assign zero_wr  = ctrl_wr && (reg_wdata_i == '0);
  assign accept   = ctrl_q[CTRL_EN] && !ctrl_q[CTRL_RST] && !fifo_full;
  assign push     = data_wr && accept;
  assign drop     = data_wr && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      total_q <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q  <= reg_wdata_i;
      if (total_wr) total_q <= CNT_W'(reg_wdata_i);
    end
  end

  cfg_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .wdata_i (reg_wdata_i),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );

  cfg_byte_ser #(.WORD_W(32), .BYTE_W(8)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .run_i   (run),
    .avail_i (!fifo_empty),
    .word_i  (fifo_rdata),
    .pop_o   (fifo_pop),
    .data_o  (cfg_data_o),
    .valid_o (cfg_valid_o),
    .ready_i (cfg_ready_i),
    .fire_o  (fire)
  );

  cfg_seq #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q[CTRL_EN]),
    .rstb_i     (ctrl_q[CTRL_RST]),
    .dma_i      (ctrl_q[CTRL_DMA]),
    .en_rise_i  (en_rise),
    .zero_wr_i  (zero_wr),
    .fire_i     (fire),
    .drop_i     (drop),
    .tgt_done_i (tgt_done_i),
    .tgt_err_i  (tgt_err_i),
    .total_i    (total_q),
    .fifo_cnt_i (fifo_cnt),
    .run_o      (run),
    .flush_o    (flush),
    .consumed_o (consumed),
    .ok_o       (ok),
    .terr_o     (terr),
    .ovf_o      (ovf),
    .nodone_o   (nodone),
    .irq_o      (irq_o),
    .dma_req_o  (dma_req_o),
    .cfg_rst_o  (cfg_rst_o)
  );

  always_comb begin
    status            = '0;
    status[ST_OK]     = ok;
    status[ST_TERR]   = terr;
    status[ST_OVF]    = ovf;
    status[ST_NODONE] = nodone;
    status[ST_DONE]   = tgt_done_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (!win) begin
      case (reg_addr_i[2:0])
        RI_CTRL:  reg_rdata_o = ctrl_q;
        RI_STAT:  reg_rdata_o = status;
        RI_CAP:   reg_rdata_o = CAP_BYTES;
        RI_USED:  reg_rdata_o = REG_W'(fifo_cnt) << 2;
        RI_TOTAL: reg_rdata_o = REG_W'(total_q);
        RI_CONS:  reg_rdata_o = REG_W'(consumed);
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_stream_ctrl_chk.sv
module cfg_stream_ctrl_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [7:0]        cfg_data_o,
  input logic              cfg_valid_o,
  input logic              cfg_ready_i,
  input logic              tgt_err_i,
  input logic              cfg_rst_o,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic              dma_bit_i,
  input logic [CW-1:0]     fifo_cnt_i,
  input logic [CNT_W-1:0]  consumed_i,
  input logic [CNT_W-1:0]  total_i
);
  logic ctrl_zero;
  assign ctrl_zero = reg_wr_i && (reg_addr_i == '0) && (reg_wdata_i == '0);

  assert_rst_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_o |-> !cfg_valid_o);

  assert_hold_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && !cfg_ready_i && !reg_wr_i && !tgt_err_i
    |=> cfg_valid_o && $stable(cfg_data_o));

  assert_zero_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_zero |=> !irq_o && !cfg_valid_o && !dma_req_o);

  assert_dma_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> dma_bit_i && ((CW'(DEPTH) - fifo_cnt_i) >= CW'(DEPTH / 2)));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(DEPTH));

  assert_stop_at_total_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (consumed_i != total_i));
endmodule

bind cfg_stream_ctrl cfg_stream_ctrl_chk #(
  .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cfg_data_o  (cfg_data_o),
  .cfg_valid_o (cfg_valid_o),
  .cfg_ready_i (cfg_ready_i),
  .tgt_err_i   (tgt_err_i),
  .cfg_rst_o   (cfg_rst_o),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .dma_bit_i   (ctrl_q[2]),
  .fifo_cnt_i  (fifo_cnt),
  .consumed_i  (consumed),
  .total_i     (total_q)
);

// File: tb/cfg_stream_ctrl_tb.sv
module cfg_stream_ctrl_tb;
  localparam int unsigned DEPTH = 8;
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_CAP = 4'd2, A_USED = 4'd3,
                         A_TOTAL = 4'd4, A_CONS = 4'd5, A_DATA = 4'd8;
  localparam logic [31:0] VEC [4] = '{32'hA1B2C3D4, 32'h00FF7E81, 32'h5A5AA5A5, 32'h80000001};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, cfg_ready = 1'b0, tgt_done = 1'b0, tgt_err = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic [7:0] cfg_data;
  logic cfg_valid, cfg_rst, irq, dma_req;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cfg_stream_ctrl #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cfg_data_o(cfg_data),
    .cfg_valid_o(cfg_valid), .cfg_ready_i(cfg_ready), .tgt_done_i(tgt_done),
    .tgt_err_i(tgt_err), .cfg_rst_o(cfg_rst), .irq_o(irq), .dma_req_o(dma_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #2 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic take(input logic [7:0] exp, input string tag);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (cfg_valid) break;
    end
    cfg_ready = 1'b1; #1;
    chk({tag, " valid"}, {31'b0, cfg_valid}, 32'd1);
    chk({tag, " byte"}, {24'b0, cfg_data}, {24'b0, exp});
    @(posedge clk); #1 cfg_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    #3 rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 32'h0);
    rd(A_STAT, rv); chk("R1 status", rv, 32'h0);
    chk("R1 outs", {28'b0, irq, cfg_rst, dma_req, cfg_valid}, 32'h0);
    rd(A_CAP, rv); chk("R5 capacity", rv, 32'(DEPTH * 4));
    // R11 done mirror
    tgt_done = 1'b1;
    rd(A_STAT, rv); chk("R11 done bit", rv, 32'h0004_0000);
    tgt_done = 1'b0;
    // R3 write while disabled
    wr(A_DATA, 32'h1234_5678);
    rd(A_STAT, rv); chk("R3 ovf disabled", rv, 32'h4);
    chk("R3 irq", {31'b0, irq}, 32'd1);
    rd(A_USED, rv); chk("R3 used", rv, 32'h0);
    wr(A_CTRL, 32'h0); #1 chk("R9 irq clear", {31'b0, irq}, 32'd0);
    // R2 reset pulse, R12 clear on enable rise
    wr(A_CTRL, 32'h3); #1 chk("R2 rst high", {31'b0, cfg_rst}, 32'd1);
    rd(A_STAT, rv); chk("R12 errs cleared", rv, 32'h0);
    rd(A_CTRL, rv); chk("R1 readback", rv, 32'h3);
    wr(A_DATA, 32'hDEAD_BEEF);
    rd(A_USED, rv); chk("R3 drop in reset", rv, 32'h0);
    wr(A_CTRL, 32'h0); #1 chk("R2 rst low", {31'b0, cfg_rst}, 32'd0);

    // run A: vector table, success
    tgt_done = 1'b1;
    wr(A_TOTAL, 32'd16);
    wr(A_CTRL, 32'h1);
    #1 chk("R10 no dma", {31'b0, dma_req}, 32'd0);
    for (int i = 0; i < 4; i++) wr(A_DATA, VEC[i]);
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 4; b++) take(VEC[i][31-8*b -: 8], "R4 msb-first");
    idle(2);
    rd(A_STAT, rv); chk("R6 status ok", rv, 32'h0004_0001);
    chk("R6 irq/valid", {30'b0, irq, cfg_valid}, 32'h2);
    rd(A_CONS, rv); chk("R5 consumed", rv, 32'd16);
    wr(A_CTRL, 32'h0); #1 chk("R9 irq clear", {31'b0, irq}, 32'd0);

    // run B: ready hold then no done
    tgt_done = 1'b0;
    wr(A_TOTAL, 32'd4);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, rv); chk("R12 ok cleared", rv, 32'h0);
    rd(A_CONS, rv); chk("R12 cons cleared", rv, 32'h0);
    wr(A_DATA, 32'hC0FF_EE11);
    idle(3); #1
    chk("R4 hold valid", {31'b0, cfg_valid}, 32'd1);
    chk("R4 hold byte", {24'b0, cfg_data}, 32'hC0);
    idle(2); #1
    chk("R4 still held", {24'b0, cfg_data}, 32'hC0);
    take(8'hC0, "R4"); take(8'hFF, "R4"); take(8'hEE, "R4"); take(8'h11, "R4");
    idle(2);
    rd(A_STAT, rv); chk("R7 nodone", rv, 32'h8);
    chk("R7 irq", {31'b0, irq}, 32'd1);

    // run C: error in the completion cycle
    wr(A_CTRL, 32'h0);
    tgt_done = 1'b1;
    wr(A_CTRL, 32'h1);
    wr(A_DATA, 32'h0102_0304);
    take(8'h01, "R8"); take(8'h02, "R8"); take(8'h03, "R8"); take(8'h04, "R8");
    tgt_err = 1'b1;
    @(posedge clk); #1 tgt_err = 1'b0;
    idle(1);
    rd(A_STAT, rv); chk("R8 err wins", rv, 32'h0004_0002);
    chk("R8 irq", {31'b0, irq}, 32'd1);

    // FIFO full overflow
    wr(A_CTRL, 32'h0);
    tgt_done = 1'b0;
    wr(A_TOTAL, 32'd64);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < DEPTH + 1; i++) wr(A_DATA, 32'(i));
    rd(A_STAT, rv); chk("R3 not yet full", rv, 32'h0);
    wr(A_DATA, 32'hFFFF_FFFF);
    rd(A_STAT, rv); chk("R3 ovf full", rv, 32'h4);
    rd(A_USED, rv); chk("R5 used full", rv, 32'(DEPTH * 4));
    wr(A_CTRL, 32'h0);
    rd(A_USED, rv); chk("R9 flushed", rv, 32'h0);
    chk("R9 irq clear", {31'b0, irq}, 32'd0);

    // DMA pacing
    wr(A_CTRL, 32'h5);
    #1 chk("R10 req empty", {31'b0, dma_req}, 32'd1);
    for (int i = 0; i < DEPTH / 2 + 1; i++) wr(A_DATA, 32'(i));
    #1 chk("R10 req half free", {31'b0, dma_req}, 32'd1);
    wr(A_DATA, 32'h55);
    #1 chk("R10 req off", {31'b0, dma_req}, 32'd0);
    rd(A_USED, rv); chk("R5 used dma", rv, 32'd20);
    take(8'h00, "R10 drain");
    chk("R9 valid before clear", {31'b0, cfg_valid}, 32'd1);
    wr(A_CTRL, 32'h0); #1
    chk("R9 stopped", {30'b0, dma_req, cfg_valid}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule